// File: doc/BRIEF.md
# Preference and Deny Bus Arbiter

This block hands a single shared bus to one of five requesters at a time. Each requester has a request line and receives a one-hot grant. The owner keeps the grant until it pulses `done`. A 32-bit control word is written through a simple write strobe. It carries a deny bit per source that keeps that source off the bus, and a preference bit per source. A preferred source is guaranteed every second arbitration. The slots in between are shared round-robin among the other eligible requesters. The same word holds a hold-time limit. An owner that keeps the bus longer than the limit without `done` loses the grant and causes a one-cycle `tmo_err` pulse.

The request/grant pair acts as a handshake. Once a requester raises `req` it keeps it high until it is granted. It then keeps using the bus until it pulses `done` or until the hold limit is reached. The arbiter grants only from the idle state, so one idle cycle always separates two owners. Sources are numbered 0 to 4. Source 4 is the host processor. It has no deny bit and is always eligible.

Top module: `bus_owner_arb`

## Requirements
- R1: After reset `grant` and `tmo_err` are 0. Sources 0 to 3 are denied, no preference is set and the hold limit is 8191, so only source 4 can be granted.
- R2: Control word bits 0, 2, 4 and 6 are the deny bits of sources 0, 1, 2 and 3. A source whose deny bit is 1 at the arbitration edge is never granted. Source 4 has no deny bit.
- R3: `grant` is one-hot or zero. If the bus is idle and some eligible source requests, a grant appears on the next rising edge. While granted, `done` high at an edge clears the grant at that edge. Without `done` the grant is unchanged except on timeout.
- R4: Control word bits 1, 3, 5, 7 and 9 are the preference bits of sources 0 to 4. Arbitrations alternate between a preference slot and a shared slot, and the first arbitration after reset is a preference slot. In a preference slot the preferred source wins if it is eligible and requesting.
- R5: If more than one preference bit is set, only the lowest-numbered source is treated as preferred.
- R6: A shared slot goes round-robin among the eligible requesters other than the preferred source. The search starts after the previous round-robin winner, which is source 4 after reset. The preferred source takes a shared slot only if it is the sole eligible requester.
- R7: If the preferred source is not eligible and requesting in its preference slot, that slot is decided round-robin and the slot order still advances.
- R8: Control word bits 31:19 hold the hold limit T. If the owner has held the grant for T cycles with `done` low in all of them, the grant is cleared at the next edge and `tmo_err` is high for exactly that one cycle. T = 0 disables the limit.
- R9: A control write takes effect from the edge that captures it. An arbitration at that same edge still uses the previous settings.
- R10: After a timeout the idle cycle that carries `tmo_err` arbitrates normally, so a waiting request is granted one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Request line per source |
| done | input | 1 | Owner releases the bus |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| grant | output | 5 | One-hot bus grant |
| tmo_err | output | 1 | One-cycle hold-timeout pulse |

## Verification
The expected timing is as follows:
- A grant is due one rising edge after an idle cycle in which an eligible request is present.
- A release is due one edge after `done` is seen high with a grant.
- `tmo_err` is due at the edge after the T-th held cycle, in the same cycle that `grant` returns to zero.
- A control write alters only arbitrations at later edges.

The bench drives every input at the falling edge. Its behavioural reference advances at the rising edge from those same inputs. The outputs are compared at the next falling edge, after every register on the path has updated. The `done` responder follows the reference's grant, so release timing does not depend on the design under test.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned CTRL_W = 32;

  typedef enum logic {
    SLOT_SHARED = 1'b0,
    SLOT_PREF   = 1'b1
  } slot_e;

  function automatic int unsigned deny_pos(int unsigned src);
    return 2 * src;
  endfunction

  function automatic int unsigned pref_pos(int unsigned src);
    return 2 * src + 1;
  endfunction
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
  import arb_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned TMO_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [NSRC-1:0]   deny_vec,
  output logic [NSRC-1:0]   pref_oh,
  output logic              pref_any,
  output logic [TMO_W-1:0]  tmo_lim
);
  logic [NSRC-2:0]  deny_q;
  logic [NSRC-1:0]  pref_q;
  logic [TMO_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_q <= '1;
      pref_q <= '0;
      lim_q  <= '1;
    end else if (wr_en) begin
      for (int unsigned i = 0; i < NSRC - 1; i++) deny_q[i] <= wr_data[deny_pos(i)];
      for (int unsigned i = 0; i < NSRC; i++)     pref_q[i] <= wr_data[pref_pos(i)];
      lim_q <= wr_data[CTRL_W-1 -: TMO_W];
    end
  end

  // last source has no deny bit: always eligible
  assign deny_vec = {1'b0, deny_q};
  // isolate lowest set preference bit
  assign pref_oh  = pref_q & (~pref_q + NSRC'(1));
  assign pref_any = |pref_q;
  assign tmo_lim  = lim_q;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] win
);
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = int'(last) + k;
      if (c >= int'(N)) c = c - int'(N);
      if (!found && mask[c]) begin
        found = 1'b1;
        win   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
  parameter int unsigned TMO_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             done,
  input  logic [TMO_W-1:0] lim,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + TMO_W'(1);
  end

  // limit of zero switches the check off
  assign expire = active && !done && (lim != '0) && (cnt_q == lim - TMO_W'(1));
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
  import arb_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned TMO_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic              done,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [NSRC-1:0]   grant,
  output logic              tmo_err
);
  localparam int unsigned IW = $clog2(NSRC);

  logic [NSRC-1:0]  deny_vec, pref_oh, elig, others, rr_mask, nxt_grant, grant_q;
  logic [TMO_W-1:0] tmo_lim;
  logic             pref_any, rr_found, use_pref, arb_go, owned, expire, release_now, tmo_q;
  logic [IW-1:0]    rr_idx, last_q;
  slot_e            slot_q;

  arb_ctrl_reg #(.NSRC(NSRC), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .deny_vec(deny_vec), .pref_oh(pref_oh), .pref_any(pref_any), .tmo_lim(tmo_lim)
  );

  assign elig    = req & ~deny_vec;
  assign others  = elig & ~pref_oh;
  assign rr_mask = (|others) ? others : elig;

  arb_rr_pick #(.N(NSRC), .IW(IW)) u_rr (
    .mask(rr_mask), .last(last_q), .found(rr_found), .win(rr_idx)
  );

  assign owned       = |grant_q;
  assign arb_go      = !owned && rr_found;
  assign use_pref    = pref_any && (slot_q == SLOT_PREF) && |(pref_oh & elig);
  assign nxt_grant   = use_pref ? pref_oh : (NSRC'(1) << rr_idx);
  assign release_now = owned && (done || expire);

  arb_hold_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(arb_go), .active(owned),
    .done(done), .lim(tmo_lim), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      tmo_q   <= 1'b0;
      slot_q  <= SLOT_PREF;
      last_q  <= IW'(NSRC - 1);
    end else begin
      tmo_q <= expire;
      if (release_now) begin
        grant_q <= '0;
      end else if (arb_go) begin
        grant_q <= nxt_grant;
        slot_q  <= (slot_q == SLOT_PREF) ? SLOT_SHARED : SLOT_PREF;
        if (!use_pref) last_q <= rr_idx;
      end
    end
  end

  assign grant   = grant_q;
  assign tmo_err = tmo_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] grant,
  input logic            done,
  input logic            tmo_err,
  input logic [NSRC-1:0] deny_vec
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_no_denied_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ((grant & $past(deny_vec)) == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> (grant == $past(grant) || tmo_err));

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && done) |=> (grant == '0));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err);

  a_r8_revoke: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (grant == '0 && $past(grant) != '0));
endmodule

bind bus_owner_arb arb_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .done(done),
  .tmo_err(tmo_err), .deny_vec(deny_vec)
);

// File: tb/bus_owner_arb_tb.sv
module bus_owner_arb_tb;
  localparam int CLK_P = 10;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic          done = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [NS-1:0] grant;
  logic          tmo_err;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  bus_owner_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .grant(grant), .tmo_err(tmo_err)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  logic [NS-1:0] m_grant, m_deny, m_pref;
  logic          m_tmo;
  int m_turn, m_last, m_hold, m_lim;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_grant = '0; m_tmo = 0; m_turn = 1; m_last = NS - 1; m_hold = 0;
      m_deny = 5'b01111; m_pref = '0; m_lim = 8191;
    end else begin
      logic [NS-1:0] elig, pool;
      int pidx, win;
      m_tmo = 0;
      if (m_grant != 0) begin
        if (done) m_grant = '0;
        else if (m_lim != 0 && m_hold == m_lim - 1) begin m_grant = '0; m_tmo = 1; end
        else m_hold++;
      end else begin
        elig = req & ~m_deny;
        if (elig != 0) begin
          pidx = -1;
          for (int i = 0; i < NS; i++) if (m_pref[i] && pidx < 0) pidx = i;
          if (m_turn == 1 && pidx >= 0 && elig[pidx]) win = pidx;
          else begin
            pool = elig;
            if (pidx >= 0 && (elig & ~(5'b1 << pidx)) != 0) pool[pidx] = 1'b0;
            win = -1;
            for (int k = 1; k <= NS; k++) begin
              int c;
              c = (m_last + k) % NS;
              if (win < 0 && pool[c]) win = c;
            end
            m_last = win;
          end
          m_grant = 5'b1 << win;
          m_turn = 1 - m_turn;
          m_hold = 0;
        end
      end
      if (cfg_wr) begin
        for (int i = 0; i < NS - 1; i++) m_deny[i] = cfg_wdata[2*i];
        m_deny[NS-1] = 1'b0;
        for (int i = 0; i < NS; i++) m_pref[i] = cfg_wdata[2*i+1];
        m_lim = int'(cfg_wdata[31:19]);
      end
    end
  end

  int auto_done = 1;
  int hold_len = 2;
  int gcnt = 0;
  int tmo_seen = 0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      check(grant === m_grant, "grant", 32'(grant), 32'(m_grant));
      check(tmo_err === m_tmo, "tmo_err", 32'(tmo_err), 32'(m_tmo));
      if (tmo_err) tmo_seen++;
      if (m_grant != 0) gcnt++; else gcnt = 0;
      done = (auto_done != 0) && (m_grant != 0) && (gcnt >= hold_len);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] dn, input logic [4:0] pf, input int lim);
    logic [31:0] w;
    w = 32'(lim) << 19;
    for (int i = 0; i < 4; i++) w[2*i] = dn[i];
    for (int i = 0; i < 5; i++) w[2*i+1] = pf[i];
    return w;
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    cfg_wdata = w; cfg_wr = 1'b1;
    run(1);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1";
    check(grant === '0, "reset grant", 32'(grant), 0);
    check(tmo_err === 1'b0, "reset tmo", 32'(tmo_err), 0);
    rst_n = 1'b1;
    req = 5'b11111;
    run(2);
    tag = "R1";
    check(grant === 5'b10000, "only src4 after reset", 32'(grant), 32'h10);
    run(20);

    tag = "R6"; write_cfg(mk(4'b0000, 5'b00000, 100)); run(40);
    tag = "R4"; write_cfg(mk(4'b0000, 5'b00100, 100)); run(40);
    tag = "R5"; write_cfg(mk(4'b0000, 5'b01010, 100)); run(40);
    tag = "R7"; req = 5'b11110;
    write_cfg(mk(4'b0000, 5'b00001, 100)); run(30);
    tag = "R6"; req = 5'b00001; run(12);
    tag = "R2"; req = 5'b11111;
    write_cfg(mk(4'b1010, 5'b00000, 100)); run(40);
    tag = "R3"; req = 5'b00110; hold_len = 4; run(30);
    req = 5'b00000; run(8);
    tag = "R9"; req = 5'b11111; hold_len = 1;
    write_cfg(mk(4'b0101, 5'b10000, 100)); write_cfg(mk(4'b0000, 5'b00010, 100)); run(30);

    tag = "R8"; auto_done = 0; tmo_seen = 0;
    write_cfg(mk(4'b0000, 5'b00000, 3)); run(40);
    check(tmo_seen > 0, "timeouts observed", 32'(tmo_seen), 1);
    tag = "R10"; req = 5'b00100; run(20);
    tag = "R8"; tmo_seen = 0;
    write_cfg(mk(4'b0000, 5'b00000, 0)); run(60);
    check(tmo_seen == 0, "limit zero disables timeout", 32'(tmo_seen), 0);
    check(grant === 5'b00100, "grant kept without limit", 32'(grant), 32'h4);
    auto_done = 1; hold_len = 1; run(10);
    tag = "R8"; write_cfg(mk(4'b0000, 5'b00000, 1)); auto_done = 0; req = 5'b11111; run(30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule